// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides the outcome of a conditional branch that applies to a whole vector of condition fields rather than to a single bit. After a start pulse it walks element indices from 0 up to the vector length minus one, one element per clock. For each element it reads a 4-bit field from an external 128-entry condition register file and tests one bit of that field against a wanted sense. A per-element predicate bit can mask the element, and an "all" flag chooses how the element results combine: any element succeeding takes the branch, or every element must succeed. The walk ends early as soon as the outcome is settled.

On completion the block pulses `done`. It then presents the taken flag, a link-register write enable, the updated loop counter and the vector length. The length may have been shortened, depending on the mode and on the outcome. Two mode bits choose whether the counter is reduced by one or by the whole vector length, and whether the length is truncated. The block holds these results until the next evaluation completes. The surrounding pipeline uses them to redirect fetch and to write back the counter, the length and the link register.

The controller has three states. `ST_IDLE` waits for `start`. `ST_EVAL` tests one element per cycle. `ST_DONE` lasts one cycle and drives `done`. The transitions are:
- *launch*: `ST_IDLE` to `ST_EVAL`, on `start` with a non-zero length.
- *empty*: `ST_IDLE` to `ST_DONE`, on `start` with zero length.
- *advance*: `ST_EVAL` to `ST_EVAL`, when the current element settles nothing and is not the last.
- *settle*: `ST_EVAL` to `ST_DONE`, on an early exit or at the last element.
- *retire*: `ST_DONE` to `ST_IDLE`, always.

Top module: `vbranch_eval`

## Requirements
- R1: `mode[1]` set selects counter mode and `mode[0]` set selects length-set mode. The codes are 00 normal, 01 length-set, 10 counter, 11 counter plus length-set.
- R2: Element i reads field index `(field_base + i) mod 128` on `cr_rd_idx`. The tested bit is `cr_rd_data[bit_sel]`, where bit 0 is the least significant. An element is successful when that bit equals `sense`.
- R3: With `all_mode` = 0, evaluation stops at the first successful element and the branch is taken. If no element succeeds, the branch is not taken and the stop index is VL-1.
- R4: With `all_mode` = 1, evaluation stops at the first failing element and the branch is not taken. If no element fails, the branch is taken and the stop index is VL-1. This includes the case where every element is skipped.
- R5: With `scalar` = 1, only element 0 (field `field_base`) is evaluated and the stop index is 0.
- R6: An element whose `pred_mask` bit is 0 is skipped when `sz` = 0. When `sz` = 1, that element takes the success value `snz` instead of reading the field.
- R7: `lr_we` = `link` AND (taken OR NOT `lr_cond`).
- R8: In length-set mode, `vl_out` is the stop index plus one when the taken flag equals `vsb`, and the stop index otherwise. In other modes `vl_out` equals `vl_in`.
- R9: In counter mode, `ctr_out` = `ctr_in` − `vl_in`. Otherwise `ctr_out` = `ctr_in` − 1. In both cases the result saturates at zero.
- R10: With `vl_in` = 0, `done` rises in the cycle after `start`. The branch is not taken, `lr_we` = 0, `ctr_out` = `ctr_in` and `vl_out` = 0.
- R11: `done` is a one-cycle pulse. It is first visible s+2 falling edges after the falling edge that raised `start`, where s is the stop index. Results hold their values while `done` is low, and `start` is accepted only in `ST_IDLE`. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (sampled in `ST_IDLE`) |
| mode | input | 2 | Mode code: bit 1 counter, bit 0 length-set |
| all_mode | input | 1 | 1 = every element must succeed, 0 = any element |
| lr_cond | input | 1 | Write the link register only when taken |
| link | input | 1 | Link request of the branch |
| vsb | input | 1 | Outcome that gives the longer truncated length |
| sz | input | 1 | Zeroing: masked elements use `snz` |
| snz | input | 1 | Success value for masked elements under zeroing |
| sense | input | 1 | Bit value that counts as success |
| scalar | input | 1 | Condition operand is scalar |
| field_base | input | 7 | First condition field index |
| bit_sel | input | 2 | Bit tested inside each field |
| pred_mask | input | VLMAX (64) | Predicate bit per element |
| vl_in | input | VLW (7) | Vector length, at most VLMAX |
| ctr_in | input | CTRW (16) | Loop counter before the branch |
| cr_rd_idx | output | 7 | Condition field read index |
| cr_rd_data | input | 4 | Field returned for `cr_rd_idx` (same cycle) |
| done | output | 1 | Results valid pulse |
| taken | output | 1 | Branch outcome |
| lr_we | output | 1 | Link register write enable |
| ctr_out | output | CTRW (16) | Updated counter |
| vl_out | output | VLW (7) | Possibly truncated vector length |

## Verification
The deciding element can also be the last element. In that case early termination and the end-of-vector condition fire in the same `ST_EVAL` cycle, and the stop index must be counted once, not advanced or doubled. The bench provokes this with a vector whose only success sits at index VL-1. It uses a base near the top of the field file, so the field index wrap lands in the same run, and it enables length-set mode. The result is judged by the latency (exactly VL+1 edges), by the taken flag and by the truncated length, which must be exactly VL-1 or VL depending on `vsb`.

// File: rtl/vbe_pkg.sv
package vbe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EVAL = 2'b01,
        ST_DONE = 2'b10
    } vbe_state_e;

    // bit 1: counter mode, bit 0: length-set mode
    typedef enum logic [1:0] {
        MD_NORMAL       = 2'b00,
        MD_LENSET       = 2'b01,
        MD_COUNT        = 2'b10,
        MD_COUNT_LENSET = 2'b11
    } vbe_mode_e;

    typedef struct packed {
        logic all_mode;
        logic lr_cond;
        logic link;
        logic vsb;
        logic sz;
        logic snz;
        logic sense;
        logic scalar;
    } vbe_flags_t;

endpackage

// File: rtl/vbe_elem.sv
module vbe_elem #(
    parameter int FIELD_W = 4,
    localparam int SEL_W  = (FIELD_W > 1) ? $clog2(FIELD_W) : 1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [SEL_W-1:0]   sel,
    input  logic               sense,
    input  logic               pred_bit,
    input  logic               sz,
    input  logic               snz,
    output logic               ok,
    output logic               skip
);

    logic [FIELD_W-1:0] pick;
    logic               tested;

    for (genvar g = 0; g < FIELD_W; g++) begin : g_pick
        assign pick[g] = field[g] & (sel == SEL_W'(g));
    end

    assign tested = |pick;

    always_comb begin
        if (pred_bit) begin
            ok   = (tested == sense);
            skip = 1'b0;
        end else if (sz) begin
            ok   = snz;
            skip = 1'b0;
        end else begin
            ok   = 1'b0;
            skip = 1'b1;
        end
    end

    // R6
    always_comb begin
        if (!pred_bit && !sz) begin
            masked_skip_chk: assert (skip);
        end
    end

endmodule

// File: rtl/vbe_result.sv
module vbe_result
    import vbe_pkg::*;
#(
    parameter int VLW  = 7,
    parameter int CTRW = 16
) (
    input  vbe_mode_e          mode,
    input  logic               vsb,
    input  logic               link,
    input  logic               lr_cond,
    input  logic [VLW-1:0]     vl,
    input  logic [CTRW-1:0]    ctr,
    input  logic               taken,
    input  logic [VLW-1:0]     stop_idx,
    output logic               lr_we,
    output logic [CTRW-1:0]    ctr_new,
    output logic [VLW-1:0]     vl_new
);

    logic            count_md;
    logic            lenset_md;
    logic [CTRW-1:0] sub;

    assign count_md  = (mode == MD_COUNT)  || (mode == MD_COUNT_LENSET);
    assign lenset_md = (mode == MD_LENSET) || (mode == MD_COUNT_LENSET);

    always_comb begin
        sub     = count_md ? CTRW'(vl) : CTRW'(1);
        ctr_new = (ctr > sub) ? (ctr - sub) : '0;
    end

    always_comb begin
        if (lenset_md) begin
            vl_new = (taken == vsb) ? (stop_idx + VLW'(1)) : stop_idx;
        end else begin
            vl_new = vl;
        end
    end

    assign lr_we = link & (taken | ~lr_cond);

    // R8
    always_comb begin
        if (stop_idx < vl) begin
            vl_new_bound_chk: assert (vl_new <= vl);
        end
    end

endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
    import vbe_pkg::*;
#(
    parameter int VLMAX   = 64,
    parameter int NFIELD  = 128,
    parameter int FIELD_W = 4,
    parameter int CTRW    = 16,
    localparam int VLW    = $clog2(VLMAX + 1),
    localparam int IW     = (VLMAX > 1) ? $clog2(VLMAX) : 1,
    localparam int FW     = $clog2(NFIELD),
    localparam int SEL_W  = (FIELD_W > 1) ? $clog2(FIELD_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic               all_mode,
    input  logic               lr_cond,
    input  logic               link,
    input  logic               vsb,
    input  logic               sz,
    input  logic               snz,
    input  logic               sense,
    input  logic               scalar,
    input  logic [FW-1:0]      field_base,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic [VLMAX-1:0]   pred_mask,
    input  logic [VLW-1:0]     vl_in,
    input  logic [CTRW-1:0]    ctr_in,
    output logic [FW-1:0]      cr_rd_idx,
    input  logic [FIELD_W-1:0] cr_rd_data,
    output logic               done,
    output logic               taken,
    output logic               lr_we,
    output logic [CTRW-1:0]    ctr_out,
    output logic [VLW-1:0]     vl_out
);

    vbe_state_e state_q, state_d;

    vbe_mode_e          mode_q;
    vbe_flags_t         flg_q;
    logic [FW-1:0]      base_q;
    logic [SEL_W-1:0]   bsel_q;
    logic [VLMAX-1:0]   pred_q;
    logic [VLW-1:0]     vl_q;
    logic [CTRW-1:0]    ctr_q;
    logic [IW-1:0]      idx_q;

    logic               taken_q;
    logic               lr_q;
    logic [CTRW-1:0]    ctrout_q;
    logic [VLW-1:0]     vlout_q;

    logic               el_ok;
    logic               el_skip;
    logic               el_hit;
    logic               el_last;
    logic               stop;
    logic               taken_n;
    logic               lr_n;
    logic [CTRW-1:0]    ctr_n;
    logic [VLW-1:0]     vl_n;
    logic [VLW-1:0]     stop_idx;
    logic               launch_zero;

    // ---------------- element evaluation ----------------
    assign cr_rd_idx = base_q + FW'(idx_q);

    vbe_elem #(
        .FIELD_W (FIELD_W)
    ) u_elem (
        .field    (cr_rd_data),
        .sel      (bsel_q),
        .sense    (flg_q.sense),
        .pred_bit (pred_q[idx_q]),
        .sz       (flg_q.sz),
        .snz      (flg_q.snz),
        .ok       (el_ok),
        .skip     (el_skip)
    );

    // a decisive element: success under "any", failure under "all"
    assign el_hit   = !el_skip && (flg_q.all_mode ? !el_ok : el_ok);
    assign el_last  = flg_q.scalar || (VLW'(idx_q) == (vl_q - VLW'(1)));
    assign stop     = (state_q == ST_EVAL) && (el_hit || el_last);
    assign taken_n  = flg_q.all_mode ^ el_hit;
    assign stop_idx = VLW'(idx_q);

    vbe_result #(
        .VLW  (VLW),
        .CTRW (CTRW)
    ) u_result (
        .mode     (mode_q),
        .vsb      (flg_q.vsb),
        .link     (flg_q.link),
        .lr_cond  (flg_q.lr_cond),
        .vl       (vl_q),
        .ctr      (ctr_q),
        .taken    (taken_n),
        .stop_idx (stop_idx),
        .lr_we    (lr_n),
        .ctr_new  (ctr_n),
        .vl_new   (vl_n)
    );

    assign launch_zero = (vl_in == '0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = launch_zero ? ST_DONE : ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (stop) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- operand latch, step counter and results ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_NORMAL;
            flg_q    <= '0;
            base_q   <= '0;
            bsel_q   <= '0;
            pred_q   <= '0;
            vl_q     <= '0;
            ctr_q    <= '0;
            idx_q    <= '0;
            taken_q  <= 1'b0;
            lr_q     <= 1'b0;
            ctrout_q <= '0;
            vlout_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q         <= vbe_mode_e'(mode);
                        flg_q.all_mode <= all_mode;
                        flg_q.lr_cond  <= lr_cond;
                        flg_q.link     <= link;
                        flg_q.vsb      <= vsb;
                        flg_q.sz       <= sz;
                        flg_q.snz      <= snz;
                        flg_q.sense    <= sense;
                        flg_q.scalar   <= scalar;
                        base_q         <= field_base;
                        bsel_q         <= bit_sel;
                        pred_q         <= pred_mask;
                        vl_q           <= vl_in;
                        ctr_q          <= ctr_in;
                        idx_q          <= '0;
                        if (launch_zero) begin
                            taken_q  <= 1'b0;
                            lr_q     <= 1'b0;
                            ctrout_q <= ctr_in;
                            vlout_q  <= '0;
                        end
                    end
                end
                ST_EVAL: begin
                    if (stop) begin
                        taken_q  <= taken_n;
                        lr_q     <= lr_n;
                        ctrout_q <= ctr_n;
                        vlout_q  <= vl_n;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                ST_DONE: begin
                    idx_q <= '0;
                end
                default: begin
                    idx_q <= '0;
                end
            endcase
        end
    end

    assign done    = (state_q == ST_DONE);
    assign taken   = taken_q;
    assign lr_we   = lr_q;
    assign ctr_out = ctrout_q;
    assign vl_out  = vlout_q;

    // ---------------- assertions ----------------
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({taken_q, lr_q, ctrout_q, vlout_q}));

    // R9
    ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctr_out <= ctr_q));

    // R8
    vl_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_q));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (vl_q == '0)) |-> (!taken && !lr_we && ctr_out == ctr_q && vl_out == '0));

    // R5
    scalar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && flg_q.scalar) |-> (idx_q == '0));

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |-> (VLW'(idx_q) < vl_q));

    // R7
    lr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lr_we) |-> flg_q.link);

endmodule

// File: tb/vbranch_eval_tb.sv
module vbranch_eval_tb;

    localparam int VLMAX = 64;
    localparam int VLW   = 7;
    localparam int CTRW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       b_mode = 2'b00;
    logic             b_all = 1'b0, b_lrc = 1'b0, b_link = 1'b0, b_vsb = 1'b0;
    logic             b_sz = 1'b0, b_snz = 1'b0, b_sense = 1'b1, b_scalar = 1'b0;
    logic [6:0]       b_base = '0;
    logic [1:0]       b_bsel = '0;
    logic [VLMAX-1:0] b_pred = '1;
    logic [VLW-1:0]   b_vl = '0;
    logic [CTRW-1:0]  b_ctr = '0;

    logic [6:0]       cr_rd_idx;
    logic [3:0]       cr_rd_data;
    logic             done, taken, lr_we;
    logic [CTRW-1:0]  ctr_out;
    logic [VLW-1:0]   vl_out;

    logic [3:0]       cr_mem [128];

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign cr_rd_data = cr_mem[cr_rd_idx];

    vbranch_eval u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (b_mode),
        .all_mode   (b_all),
        .lr_cond    (b_lrc),
        .link       (b_link),
        .vsb        (b_vsb),
        .sz         (b_sz),
        .snz        (b_snz),
        .sense      (b_sense),
        .scalar     (b_scalar),
        .field_base (b_base),
        .bit_sel    (b_bsel),
        .pred_mask  (b_pred),
        .vl_in      (b_vl),
        .ctr_in     (b_ctr),
        .cr_rd_idx  (cr_rd_idx),
        .cr_rd_data (cr_rd_data),
        .done       (done),
        .taken      (taken),
        .lr_we      (lr_we),
        .ctr_out    (ctr_out),
        .vl_out     (vl_out)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_defaults();
        for (int i = 0; i < 128; i++) cr_mem[i] = 4'h0;
        b_mode = 2'b00; b_all = 1'b0; b_lrc = 1'b0; b_link = 1'b0; b_vsb = 1'b0;
        b_sz = 1'b0; b_snz = 1'b0; b_sense = 1'b1; b_scalar = 1'b0;
        b_base = '0; b_bsel = '0; b_pred = '1; b_vl = 7'd4; b_ctr = 16'd10;
    endtask

    // Expected values derived from R2..R10, then the run is compared (R11 timing).
    task automatic run_case(string req);
        int  stop = 0;
        bit  hit = 0;
        bit  e_taken, e_lr;
        int  e_ctr, e_vl, e_lat, sub, lat;
        logic            s_taken, s_lr;
        logic [CTRW-1:0] s_ctr;
        logic [VLW-1:0]  s_vl;
        for (int i = 0; i < int'(b_vl); i++) begin
            logic [6:0] fi = b_base + 7'(i);
            bit ok = 0, skip = 0;
            if (b_pred[i]) ok = (cr_mem[fi][b_bsel] == b_sense);
            else if (b_sz) ok = b_snz;
            else skip = 1;
            stop = i;
            if (!skip && (b_all ? !ok : ok)) begin hit = 1; break; end
            if (b_scalar) break;
        end
        e_taken = (b_vl == 0) ? 1'b0 : (b_all ? !hit : hit);
        e_lr    = (b_vl == 0) ? 1'b0 : (b_link && (e_taken || !b_lrc));
        sub     = b_mode[1] ? int'(b_vl) : 1;
        e_ctr   = (b_vl == 0) ? int'(b_ctr) : ((int'(b_ctr) > sub) ? int'(b_ctr) - sub : 0);
        e_vl    = (b_vl == 0) ? 0 : (b_mode[0] ? ((e_taken == b_vsb) ? stop + 1 : stop) : int'(b_vl));
        e_lat   = (b_vl == 0) ? 1 : stop + 2;

        @(negedge clk);
        start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
        end while (!done && lat < 200);

        check("R11", {req, " latency"}, lat, e_lat);
        check(req, "taken", taken, e_taken);
        check("R7", {req, " lr_we"}, lr_we, e_lr);
        check("R9", {req, " ctr_out"}, ctr_out, e_ctr);
        check("R8", {req, " vl_out"}, vl_out, e_vl);
        s_taken = taken; s_lr = lr_we; s_ctr = ctr_out; s_vl = vl_out;
        repeat (3) @(negedge clk);
        check("R11", {req, " done pulse"}, done, 0);
        check("R11", {req, " hold"}, {s_taken, s_lr, s_ctr, s_vl} == {taken, lr_we, ctr_out, vl_out}, 1);
    endtask

    task automatic t_reset();
        check("R11", "reset done", done, 0);
        check("R11", "reset taken", taken, 0);
        check("R11", "reset lr_we", lr_we, 0);
        check("R11", "reset ctr_out", ctr_out, 0);
        check("R11", "reset vl_out", vl_out, 0);
    endtask

    // R3 first success at index 3, normal mode counter decrement (R1)
    task automatic t_any_hit();
        set_defaults();
        b_base = 7'd10; b_bsel = 2'd2; b_vl = 7'd8; b_ctr = 16'd5; b_link = 1'b1;
        cr_mem[13] = 4'b0100;
        run_case("R3");
    endtask

    // R3 no success, stop at VL-1
    task automatic t_any_miss();
        set_defaults();
        b_base = 7'd20; b_vl = 7'd5;
        run_case("R3");
    endtask

    // R4 all succeed
    task automatic t_all_pass();
        set_defaults();
        b_all = 1'b1; b_base = 7'd30; b_bsel = 2'd1; b_vl = 7'd6;
        for (int i = 30; i < 36; i++) cr_mem[i] = 4'b0010;
        run_case("R4");
    endtask

    // R4 failure at index 2
    task automatic t_all_fail();
        set_defaults();
        b_all = 1'b1; b_base = 7'd30; b_bsel = 2'd1; b_vl = 7'd6;
        for (int i = 30; i < 36; i++) cr_mem[i] = 4'b0010;
        cr_mem[32] = 4'b1101;
        run_case("R4");
    endtask

    // R2 sense 0, bit 0 selected, other bits set
    task automatic t_sense_zero();
        set_defaults();
        b_sense = 1'b0; b_base = 7'd40; b_bsel = 2'd0; b_vl = 7'd5;
        for (int i = 40; i < 45; i++) cr_mem[i] = 4'hF;
        cr_mem[42] = 4'hE;
        run_case("R2");
    endtask

    // R6 masked element skipped when sz=0
    task automatic t_skip();
        set_defaults();
        b_base = 7'd50; b_vl = 7'd6;
        cr_mem[51] = 4'h1; cr_mem[53] = 4'h1;
        b_pred = ~(64'd1 << 1);
        run_case("R6");
    endtask

    // R6 masked element takes snz when sz=1
    task automatic t_zeroing();
        set_defaults();
        b_base = 7'd70; b_vl = 7'd6; b_sz = 1'b1; b_snz = 1'b1;
        b_pred = ~(64'd1 << 2);
        run_case("R6");
    endtask

    // R4 every element skipped: vacuous success
    task automatic t_all_vacuous();
        set_defaults();
        b_all = 1'b1; b_pred = '0; b_vl = 7'd4; b_base = 7'd80;
        run_case("R4");
    endtask

    // R5 scalar operand, length-set mode with vsb=0
    task automatic t_scalar();
        set_defaults();
        b_scalar = 1'b1; b_base = 7'd60; b_vl = 7'd8; b_mode = 2'b01;
        cr_mem[61] = 4'h1;
        run_case("R5");
    endtask

    // R7 link gated by outcome
    task automatic t_link();
        set_defaults();
        b_base = 7'd20; b_vl = 7'd3; b_link = 1'b1; b_lrc = 1'b1;
        run_case("R7");
        set_defaults();
        b_base = 7'd20; b_vl = 7'd3; b_link = 1'b1; b_lrc = 1'b1;
        cr_mem[21] = 4'h1;
        run_case("R7");
    endtask

    // R8 length-set truncation for both vsb values
    task automatic t_lenset();
        set_defaults();
        b_mode = 2'b01; b_vsb = 1'b1; b_base = 7'd10; b_bsel = 2'd2; b_vl = 7'd8;
        cr_mem[13] = 4'b0100;
        run_case("R8");
        b_vsb = 1'b0;
        run_case("R8");
    endtask

    // R9 counter mode, saturation and plain subtraction; R1 combined mode
    task automatic t_count();
        set_defaults();
        b_mode = 2'b10; b_vl = 7'd8; b_ctr = 16'd5; b_base = 7'd90;
        run_case("R9");
        b_ctr = 16'd20;
        run_case("R9");
        b_mode = 2'b11; b_vsb = 1'b1;
        run_case("R1");
        set_defaults();
        b_ctr = 16'd0; b_base = 7'd90;
        run_case("R9");
    endtask

    // R10 zero length
    task automatic t_zero_len();
        set_defaults();
        b_vl = 7'd0; b_ctr = 16'd7; b_link = 1'b1; b_mode = 2'b11;
        cr_mem[0] = 4'hF;
        run_case("R10");
    endtask

    // R2 wrap of field index; decisive element is also the last one
    task automatic t_wrap_last();
        set_defaults();
        b_base = 7'd126; b_bsel = 2'd3; b_vl = 7'd4; b_mode = 2'b01; b_vsb = 1'b0;
        cr_mem[1] = 4'b1000;
        run_case("R2");
        b_vsb = 1'b1;
        run_case("R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_any_hit();
        t_any_miss();
        t_all_pass();
        t_all_fail();
        t_sense_zero();
        t_skip();
        t_zeroing();
        t_all_vacuous();
        t_scalar();
        t_link();
        t_lenset();
        t_count();
        t_zero_len();
        t_wrap_last();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule